// File: doc/BRIEF.md
# Timer/PWM unit with dead-time complementary outputs

This block is a 16-bit up-counting timer for a microcontroller peripheral set. While enabled it advances on each clock cycle in which the count-tick strobe is high. When the count reaches a programmed period value, it either wraps to zero (continuous mode) or freezes there (single-run mode). A compare value splits each period into a high phase and a low phase for the PWM signal.

The PWM signal drives a pair of outputs: a true output and its complement. A programmable dead time delays the rising edge of each output, so the two are never high together. An external event input is synchronised and edge-detected, and it snapshots the running count into a capture register. An overflow flag reports events that were lost. A kill input forces both outputs at once to programmed safe levels. After kill is released, the outputs stay at those levels until the next period boundary.

Configuration is written through a small address/data write port. Address 0 holds the period, address 1 the compare value, address 2 the dead time and address 3 the control bits.

Top module: `pwm_dt_top`

## Requirements
- R1: While `enable_i` is high and the counter is not stopped, `count_o` increments by one on each clock edge where `tick_i` is high, and holds otherwise. `enable_i` low clears the count to 0 on the next edge and also clears the stopped state.
- R2: In continuous mode (control bit 0 = 0), a tick when the count equals the period makes the count 0 on the next edge. The count sequence is 0..period.
- R3: In single-run mode (control bit 0 = 1), a tick when the count equals the period freezes the count at the period. Both outputs go low and stay low until `enable_i` drops. Re-enabling restarts from 0.
- R4: The internal PWM level is high while the counter is running and the count is below the compare value. Compare 0 gives no high phase. Compare above the period gives a constant high level.
- R5: Outside kill, `pwm_o` and `pwm_n_o` are never both high.
- R6: Each output follows its level (the true output follows the PWM level, the complement follows its inverse while running). It rises only after the level has been high for dead+1 consecutive edges, and falls one edge after the level falls. A high phase of at most `dead` cycles yields no pulse.
- R7: While `kill_i` is high, `pwm_o` equals control bit 1 and `pwm_n_o` equals control bit 2, in the same cycle that kill rises.
- R8: After `kill_i` falls, the outputs keep the kill levels until the next period boundary (the tick at count == period) or until `enable_i` drops. Normal output resumes from the following cycle.
- R9: A rising edge on `capture_i` that is first sampled at edge E0 loads `cap_o` at edge E2 with the count held just before E2, and sets `cap_valid_o`.
- R10: A capture while `cap_valid_o` is set and `cap_rd_i` is low sets `cap_ovf_o`. A `cap_rd_i` pulse without a capture clears both flags. A capture in the same cycle as `cap_rd_i` loads the value and leaves valid set and overflow clear.
- R11: Writes take effect on the edge where `cfg_we_i` is high. Address 0 is the period, 1 the compare value, 2 the dead time (low 8 bits), and 3 the control bits (bit 0 single-run, bit 1 true kill level, bit 2 complement kill level). Reset gives period 0xFFFF, compare 0, dead time 0, control 0, count 0, both outputs low and capture flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low clears the counter |
| tick_i | input | 1 | Count-tick strobe |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| capture_i | input | 1 | Asynchronous capture event |
| cap_rd_i | input | 1 | Capture read acknowledge; clears the flags |
| kill_i | input | 1 | Output kill request |
| count_o | output | 16 | Current count |
| cap_o | output | 16 | Captured count |
| cap_valid_o | output | 1 | Capture holds an unread value |
| cap_ovf_o | output | 1 | A capture was overwritten before it was read |
| pwm_o | output | 1 | True PWM output |
| pwm_n_o | output | 1 | Complementary PWM output |

## Verification
Two of the block's functions can fall in the same cycle: a synchronised capture edge and a read acknowledge. The bench times `cap_rd_i` onto the edge where the capture loads, after first leaving an unread value in the register. It then judges that the new count is stored, that valid remains set and that overflow stays clear. The kill release is also placed mid-period, so that the deferred return has to wait for the wrap edge. The bench checks that the kill levels persist through count == period and that the normal complementary levels appear when the count reads 0.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  typedef enum logic [1:0] {
    CFG_PERIOD  = 2'd0,
    CFG_COMPARE = 2'd1,
    CFG_DEAD    = 2'd2,
    CFG_CTRL    = 2'd3
  } cfg_addr_e;

  localparam int CTRL_ONESHOT = 0;
  localparam int CTRL_KILL_T  = 1;
  localparam int CTRL_KILL_C  = 2;
  localparam int CTRL_W       = 3;
  localparam int NUM_OUT      = 2;
endpackage

// File: rtl/pwm_dt_cfg.sv
module pwm_dt_cfg
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] compare_o,
  output logic [DT_W-1:0]  dead_o,
  output logic             oneshot_o,
  output logic [1:0]       kill_lvl_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[CNT_W-1:DT_W], wdata_i[DT_W-1:CTRL_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o  <= '1;
      compare_o <= '0;
      dead_o    <= '0;
      ctrl_q    <= '0;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        CFG_PERIOD:  period_o  <= wdata_i;
        CFG_COMPARE: compare_o <= wdata_i;
        CFG_DEAD:    dead_o    <= wdata_i[DT_W-1:0];
        default:     ctrl_q    <= wdata_i[CTRL_W-1:0];
      endcase
    end
  end

  assign oneshot_o  = ctrl_q[CTRL_ONESHOT];
  assign kill_lvl_o = {ctrl_q[CTRL_KILL_C], ctrl_q[CTRL_KILL_T]};

  assert_period_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> period_o == $past(wdata_i));
endmodule

// File: rtl/pwm_dt_counter.sv
module pwm_dt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             oneshot_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             boundary_o
);
  logic stopped_q;
  logic step;

  assign step       = en_i && tick_i && !stopped_q;
  assign boundary_o = step && (count_o == period_i);
  assign active_o   = en_i && !stopped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '0;
      stopped_q <= 1'b0;
    end else if (!en_i) begin
      count_o   <= '0;
      stopped_q <= 1'b0;
    end else if (step) begin
      if (count_o == period_i) begin
        if (oneshot_i) stopped_q <= 1'b1;
        else           count_o   <= '0;
      end else begin
        count_o <= count_o + 1'b1;
      end
    end
  end

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count_o != period_i) |=> count_o == $past(count_o) + 1'b1);
  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_o && !oneshot_i) |=> count_o == '0);
  assert_stop_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stopped_q && en_i) |=> ($stable(count_o) && !active_o));
endmodule

// File: rtl/pwm_dt_deadband.sv
module pwm_dt_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            out_o
);
  logic [DT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      out_o  <= 1'b0;
    end else if (!in_i) begin
      wait_q <= '0;
      out_o  <= 1'b0;
    end else if (wait_q >= dead_i) begin
      out_o  <= 1'b1;
    end else begin
      wait_q <= wait_q + 1'b1;
      out_o  <= 1'b0;
    end
  end

  assert_rise_needs_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_o) |-> $past(in_i));
  assert_fall_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_i |=> !out_o);
endmodule

// File: rtl/pwm_dt_capture.sv
module pwm_dt_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             valid_o,
  output logic             ovf_o
);
  localparam int SYNC_N = 3;
  logic [SYNC_N-1:0] sync_q;
  logic              rise;

  assign rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_N-2:0], evt_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_o   <= '0;
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (rise) begin
      cap_o   <= count_i;
      valid_o <= 1'b1;
      ovf_o   <= rd_i ? 1'b0 : (ovf_o || valid_o);
    end else if (rd_i) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end
  end

  assert_ovf_needs_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(valid_o));
  assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !rise) |=> (!valid_o && !ovf_o));
  assert_load_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> (valid_o && cap_o == $past(count_i)));
endmodule

// File: rtl/pwm_dt_top.sv
module pwm_dt_top
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic             capture_i,
  input  logic             cap_rd_i,
  input  logic             kill_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             cap_valid_o,
  output logic             cap_ovf_o,
  output logic             pwm_o,
  output logic             pwm_n_o
);
  logic [CNT_W-1:0]   period, compare;
  logic [DT_W-1:0]    dead;
  logic               oneshot, active, boundary;
  logic [1:0]         kill_lvl;
  logic               below;
  logic [NUM_OUT-1:0] lvl, db_out;
  logic               kill_hold_q, killed;

  pwm_dt_cfg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .period_o(period), .compare_o(compare), .dead_o(dead),
    .oneshot_o(oneshot), .kill_lvl_o(kill_lvl)
  );

  pwm_dt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(enable_i), .tick_i, .period_i(period), .oneshot_i(oneshot),
    .count_o, .active_o(active), .boundary_o(boundary)
  );

  pwm_dt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni,
    .evt_i(capture_i), .rd_i(cap_rd_i), .count_i(count_o),
    .cap_o, .valid_o(cap_valid_o), .ovf_o(cap_ovf_o)
  );

  assign below  = count_o < compare;
  assign lvl[0] = active && below;
  assign lvl[1] = active && !below;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_db
    pwm_dt_deadband #(.DT_W(DT_W)) u_db (
      .clk_i, .rst_ni, .in_i(lvl[g]), .dead_i(dead), .out_o(db_out[g])
    );
  end

  // kill takes effect combinationally; release waits for a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     kill_hold_q <= 1'b0;
    else if (kill_i)                 kill_hold_q <= 1'b1;
    else if (boundary || !enable_i)  kill_hold_q <= 1'b0;
  end

  assign killed  = kill_i || kill_hold_q;
  assign pwm_o   = killed ? kill_lvl[0] : db_out[0];
  assign pwm_n_o = killed ? kill_lvl[1] : db_out[1];

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !killed |-> !(pwm_o && pwm_n_o));
  assert_kill_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> (pwm_o == kill_lvl[0] && pwm_n_o == kill_lvl[1]));
  assert_kill_persist_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (killed && !boundary && enable_i) |=> killed);
endmodule

// File: tb/tb_pwm_dt_top.sv
module tb_pwm_dt_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        enable_i = 1'b0, tick_i = 1'b0, cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        capture_i = 1'b0, cap_rd_i = 1'b0, kill_i = 1'b0;
  logic [15:0] count_o, cap_o;
  logic        cap_valid_o, cap_ovf_o, pwm_o, pwm_n_o;
  int checks = 0, fails = 0;

  pwm_dt_top dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = 2'(a); cfg_wdata_i = 16'(d);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic setup(input int p, input int c, input int d, input int ctl);
    enable_i = 1'b0;
    wr(0, p); wr(1, c); wr(2, d); wr(3, ctl);
  endtask

  // drives an event; samples count at the load edge; returns value seen
  task automatic cap_event(input bit rd_at_load, output int v);
    @(negedge clk_i); capture_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); v = count_o; cap_rd_i = rd_at_load;
    @(negedge clk_i); cap_rd_i = 1'b0; capture_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int v, v2, prev, ht, hc, ov, et, ec;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(count_o == 0, "R11 reset count", count_o, 0);
    chk(pwm_o == 0 && pwm_n_o == 0, "R11 reset outputs", {pwm_o, pwm_n_o}, 0);
    chk(cap_valid_o == 0 && cap_ovf_o == 0, "R11 reset flags", {cap_valid_o, cap_ovf_o}, 0);

    // default config: compare 0 -> complement high
    enable_i = 1'b1; tick_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(count_o == 3, "R1 count after 3 ticks", count_o, 3);
    chk(pwm_o == 0 && pwm_n_o == 1, "R11 default compare 0", {pwm_o, pwm_n_o}, 1);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk(count_o == 0, "R1 disable clears", count_o, 0);

    // tick gating
    wr(0, 100);
    enable_i = 1'b1;
    for (int i = 0; i < 12; i++) begin
      prev = count_o; tick_i = i[0];
      @(negedge clk_i);
      chk(count_o == prev + i % 2, "R1 tick gating", count_o, prev + i % 2);
    end
    tick_i = 1'b1; enable_i = 1'b0;

    // continuous wrap, period 4
    setup(4, 2, 0, 0);
    enable_i = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk_i);
      chk(count_o == i % 5, "R2 wrap sequence", count_o, i % 5);
    end

    // sweep period / compare / dead time
    for (int p = 3; p <= 6; p++) begin
      for (int c = 0; c <= p + 1; c++) begin
        for (int d = 0; d <= 3; d++) begin
          setup(p, c, d, 0);
          enable_i = 1'b1;
          repeat (2 * (p + 1) + d + 3) @(negedge clk_i);
          ht = 0; hc = 0; ov = 0;
          for (int k = 0; k <= p; k++) begin
            @(negedge clk_i);
            ht += int'(pwm_o); hc += int'(pwm_n_o);
            if (pwm_o && pwm_n_o) ov++;
          end
          et = (c >= p + 1) ? p + 1 : ((c > d) ? c - d : 0);
          ec = (c == 0) ? p + 1 : ((p + 1 - c > d) ? p + 1 - c - d : 0);
          chk(ht == et, "R4/R6 true high cycles", ht, et);
          chk(hc == ec, "R6 complement high cycles", hc, ec);
          chk(ov == 0, "R5 overlap", ov, 0);
        end
      end
    end

    // single-run
    setup(5, 3, 0, 1);
    enable_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(count_o == 5, "R3 reaches period", count_o, 5);
    repeat (7) @(negedge clk_i);
    chk(count_o == 5, "R3 frozen", count_o, 5);
    chk(pwm_o == 0 && pwm_n_o == 0, "R3 outputs low", {pwm_o, pwm_n_o}, 0);
    enable_i = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(count_o == 2, "R3 restart", count_o, 2);

    // kill: true level 1, complement level 0
    setup(7, 4, 0, 3'b010);
    enable_i = 1'b1;
    while (count_o != 5) @(negedge clk_i);
    chk(pwm_o == 0 && pwm_n_o == 1, "R4 normal before kill", {pwm_o, pwm_n_o}, 1);
    kill_i = 1'b1; #1;
    chk(pwm_o == 1 && pwm_n_o == 0, "R7 immediate kill", {pwm_o, pwm_n_o}, 2);
    @(negedge clk_i);
    while (count_o != 2) begin
      chk(pwm_o == 1 && pwm_n_o == 0, "R7 kill held", {pwm_o, pwm_n_o}, 2);
      @(negedge clk_i);
    end
    kill_i = 1'b0; #1;
    chk(pwm_o == 1 && pwm_n_o == 0, "R8 release deferred", {pwm_o, pwm_n_o}, 2);
    do begin
      @(negedge clk_i);
      chk(pwm_o == 1 && pwm_n_o == 0, "R8 hold to boundary", {pwm_o, pwm_n_o}, 2);
    end while (count_o != 7);
    @(negedge clk_i);
    chk(count_o == 0, "R2 wrap after kill", count_o, 0);
    chk(pwm_o == 0 && pwm_n_o == 1, "R8 resume after boundary", {pwm_o, pwm_n_o}, 1);
    kill_i = 1'b1;
    wr(3, 3'b100);
    chk(pwm_o == 0 && pwm_n_o == 1, "R7 alternate kill levels", {pwm_o, pwm_n_o}, 1);
    kill_i = 1'b0;

    // capture
    setup(200, 10, 0, 0);
    enable_i = 1'b1;
    repeat (4) @(negedge clk_i);
    cap_event(1'b0, v);
    chk(cap_o == 16'(v), "R9 captured count", cap_o, v);
    chk(cap_valid_o == 1 && cap_ovf_o == 0, "R9 valid no ovf", {cap_valid_o, cap_ovf_o}, 2);
    cap_event(1'b0, v2);
    chk(cap_o == 16'(v2), "R9 second capture", cap_o, v2);
    chk(cap_ovf_o == 1, "R10 overflow", cap_ovf_o, 1);
    @(negedge clk_i); cap_rd_i = 1'b1;
    @(negedge clk_i); cap_rd_i = 1'b0;
    chk(cap_valid_o == 0 && cap_ovf_o == 0, "R10 read clears", {cap_valid_o, cap_ovf_o}, 0);
    cap_event(1'b0, v);
    chk(cap_valid_o == 1 && cap_ovf_o == 0, "R10 capture after read", {cap_valid_o, cap_ovf_o}, 2);
    cap_event(1'b1, v2);
    chk(cap_o == 16'(v2), "R10 collision value", cap_o, v2);
    chk(cap_valid_o == 1 && cap_ovf_o == 0, "R10 collision flags", {cap_valid_o, cap_ovf_o}, 2);

    finish_run();
  end
endmodule